// File: doc/BRIEF.md
# Dual-Bank Work RAM Swap Controller

This block splits a shared work RAM into two equal banks, A and B, and gives one bank to a main processor and the other to a sub processor. Neither processor can reach both banks at once. A small mode register decides the mapping, and both processors see it through their own register ports. The block sends each processor's RAM address, write strobes and data to the bank that processor owns. It returns read data from that same bank.

The sub side owns the bank-select bit and swaps the banks by toggling it. The main side asks for a swap through a request bit that has inverted write semantics. Writing 0 to that bit raises the request. The bit then reads 1 until the sub side toggles the select bit. Writing 1 does nothing. The RAM arrays are 16 bits wide with a byte write strobe per byte. With `ADDR_W` = 16, each bank holds 128 KB.

Top module: `wram_swap_ctrl`

## Requirements
- R1: After reset both register views read 0x00. Bit 0 (bank select) is 0 and bit 1 (swap request) is 0. With select 0, main owns bank A and sub owns bank B.
- R2: Main-side register writes never change bit 0. Only a sub-side write loads bit 0, and it takes bit 0 of the written byte.
- R3: With select 0, main accesses bank A and sub accesses bank B. With select 1 the banks are exchanged. A new select value applies to RAM accesses from the cycle after the sub write. An access in the same cycle as the write still uses the old mapping.
- R4: Bit 1 of a sub-side register write is ignored.
- R5: A main-side write with bit 1 = 0 sets the swap request. A main-side write with bit 1 = 1 leaves the request unchanged.
- R6: A pending request reads as 1 and stays 1 until a swap. A further main request while one is pending keeps it at 1.
- R7: A sub write that changes bit 0 clears the request on that same clock edge. Such a toggle swaps the banks even with no request pending. If a main request lands in the same cycle as a toggle, the request ends up cleared.
- R8: Both register ports always return the same byte, and bits 7:2 read 0.
- R9: A RAM access with enable high returns the word at its address on the side's read-data port one cycle later. A write updates only the bytes whose strobe bit is set (strobe bit 0 covers data bits 7:0, strobe bit 1 covers bits 15:8).
- R10: Data written by one side into its bank can be read by the other side after a swap. Writes by one side never appear in the bank the other side owns at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_reg_we | input | 1 | Main-side mode register write enable |
| main_reg_wdata | input | REG_W | Main-side register write data |
| main_reg_rdata | output | REG_W | Mode register as seen by main |
| sub_reg_we | input | 1 | Sub-side mode register write enable |
| sub_reg_wdata | input | REG_W | Sub-side register write data |
| sub_reg_rdata | output | REG_W | Mode register as seen by sub |
| main_ram_en | input | 1 | Main RAM access enable |
| main_ram_wstrb | input | 2 | Main byte write strobes (zero means read) |
| main_ram_addr | input | ADDR_W | Main word address within its bank |
| main_ram_wdata | input | 16 | Main write data |
| main_ram_rdata | output | 16 | Main read data, one cycle after access |
| sub_ram_en | input | 1 | Sub RAM access enable |
| sub_ram_wstrb | input | 2 | Sub byte write strobes (zero means read) |
| sub_ram_addr | input | ADDR_W | Sub word address within its bank |
| sub_ram_wdata | input | 16 | Sub write data |
| sub_ram_rdata | output | 16 | Sub read data, one cycle after access |

## Verification
The bench builds the block with `ADDR_W` = 6, so each bank has 64 words. That makes the top address, 63, quick to reach, and byte-strobe merges at that edge can be checked along with the low addresses. `REG_W` stays at 8, so the zero upper register bits and the ignored write bits are all visible on the ports. At this depth, one word written on each side before and after a swap shows both bank isolation and the exchange of ownership.

// File: rtl/wram_swap_pkg.sv
package wram_swap_pkg;
  localparam int WORD_W    = 16;
  localparam int LANES     = WORD_W / 8;
  localparam int NUM_BANKS = 2;
  localparam int SEL_BIT   = 0;
  localparam int REQ_BIT   = 1;

  typedef enum logic {SIDE_MAIN = 1'b0, SIDE_SUB = 1'b1} side_e;

  // Bank index owned by a side for a given select value.
  function automatic logic owned_bank(input logic sel, input side_e side);
    return (side == SIDE_MAIN) ? sel : ~sel;
  endfunction
endpackage

// File: rtl/wram_mode_reg.sv
module wram_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic main_we,
  input  logic main_req_bit,
  input  logic sub_we,
  input  logic sub_sel_bit,
  output logic sel,
  output logic req
);
  logic sel_d, req_d;
  logic toggle;
  logic sel_en, req_en;

  always_comb begin
    toggle = sub_we && (sub_sel_bit != sel);
    sel_en = sub_we;
    sel_d  = sub_sel_bit;
    req_en = toggle || (main_we && !main_req_bit);
    // A completed swap clears the request, even against a same-cycle request.
    req_d  = toggle ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= 1'b0;
      req <= 1'b0;
    end else begin
      if (sel_en) sel <= sel_d;
      if (req_en) req <= req_d;
    end
  end
endmodule

// File: rtl/wram_bank.sv
module wram_bank #(
  parameter int ADDR_W = 10
) (
  input  logic                               clk,
  input  logic                               en,
  input  logic [wram_swap_pkg::LANES-1:0]    wstrb,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [wram_swap_pkg::WORD_W-1:0]   wdata,
  output logic [wram_swap_pkg::WORD_W-1:0]   rdata
);
  import wram_swap_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      rdata <= mem[addr];
      for (int l = 0; l < LANES; l++) begin
        if (wstrb[l]) mem[addr][l*8 +: 8] <= wdata[l*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/wram_bank_router.sv
module wram_bank_router #(
  parameter int ADDR_W = 10
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sel,
  input  logic                              m_en,
  input  logic [wram_swap_pkg::LANES-1:0]   m_wstrb,
  input  logic [ADDR_W-1:0]                 m_addr,
  input  logic [wram_swap_pkg::WORD_W-1:0]  m_wdata,
  output logic [wram_swap_pkg::WORD_W-1:0]  m_rdata,
  input  logic                              s_en,
  input  logic [wram_swap_pkg::LANES-1:0]   s_wstrb,
  input  logic [ADDR_W-1:0]                 s_addr,
  input  logic [wram_swap_pkg::WORD_W-1:0]  s_wdata,
  output logic [wram_swap_pkg::WORD_W-1:0]  s_rdata
);
  import wram_swap_pkg::*;

  logic [NUM_BANKS-1:0]    b_en;
  logic [LANES-1:0]        b_wstrb [NUM_BANKS];
  logic [ADDR_W-1:0]       b_addr  [NUM_BANKS];
  logic [WORD_W-1:0]       b_wdata [NUM_BANKS];
  logic [WORD_W-1:0]       b_rdata [NUM_BANKS];
  logic                    m_pick_q, s_pick_q;
  logic                    m_pick_d, s_pick_d;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic main_owns;
    always_comb begin
      main_owns  = (owned_bank(sel, SIDE_MAIN) == 1'(b));
      b_en[b]    = main_owns ? m_en    : s_en;
      b_wstrb[b] = main_owns ? m_wstrb : s_wstrb;
      b_addr[b]  = main_owns ? m_addr  : s_addr;
      b_wdata[b] = main_owns ? m_wdata : s_wdata;
    end

    wram_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk   (clk),
      .en    (b_en[b]),
      .wstrb (b_wstrb[b]),
      .addr  (b_addr[b]),
      .wdata (b_wdata[b]),
      .rdata (b_rdata[b])
    );
  end

  always_comb begin
    m_pick_d = owned_bank(sel, SIDE_MAIN);
    s_pick_d = owned_bank(sel, SIDE_SUB);
  end

  // Remember which bank served each side's last access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pick_q <= 1'b0;
      s_pick_q <= 1'b1;
    end else begin
      if (m_en) m_pick_q <= m_pick_d;
      if (s_en) s_pick_q <= s_pick_d;
    end
  end

  assign m_rdata = b_rdata[m_pick_q];
  assign s_rdata = b_rdata[s_pick_q];
endmodule

// File: rtl/wram_swap_ctrl.sv
module wram_swap_ctrl #(
  parameter int ADDR_W = 10,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_reg_we,
  input  logic [REG_W-1:0]  main_reg_wdata,
  output logic [REG_W-1:0]  main_reg_rdata,
  input  logic              sub_reg_we,
  input  logic [REG_W-1:0]  sub_reg_wdata,
  output logic [REG_W-1:0]  sub_reg_rdata,
  input  logic              main_ram_en,
  input  logic [1:0]        main_ram_wstrb,
  input  logic [ADDR_W-1:0] main_ram_addr,
  input  logic [15:0]       main_ram_wdata,
  output logic [15:0]       main_ram_rdata,
  input  logic              sub_ram_en,
  input  logic [1:0]        sub_ram_wstrb,
  input  logic [ADDR_W-1:0] sub_ram_addr,
  input  logic [15:0]       sub_ram_wdata,
  output logic [15:0]       sub_ram_rdata
);
  import wram_swap_pkg::*;

  logic rst_sync_q1, rst_sync_q2;
  logic sel, req;
  logic [REG_W-1:0] mode_view;
  logic unused_wbits;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q1 <= 1'b0;
      rst_sync_q2 <= 1'b0;
    end else begin
      rst_sync_q1 <= 1'b1;
      rst_sync_q2 <= rst_sync_q1;
    end
  end

  wram_mode_reg u_mode (
    .clk          (clk),
    .rst_n        (rst_sync_q2),
    .main_we      (main_reg_we),
    .main_req_bit (main_reg_wdata[REQ_BIT]),
    .sub_we       (sub_reg_we),
    .sub_sel_bit  (sub_reg_wdata[SEL_BIT]),
    .sel          (sel),
    .req          (req)
  );

  wram_bank_router #(.ADDR_W(ADDR_W)) u_router (
    .clk     (clk),
    .rst_n   (rst_sync_q2),
    .sel     (sel),
    .m_en    (main_ram_en),
    .m_wstrb (main_ram_wstrb),
    .m_addr  (main_ram_addr),
    .m_wdata (main_ram_wdata),
    .m_rdata (main_ram_rdata),
    .s_en    (sub_ram_en),
    .s_wstrb (sub_ram_wstrb),
    .s_addr  (sub_ram_addr),
    .s_wdata (sub_ram_wdata),
    .s_rdata (sub_ram_rdata)
  );

  always_comb begin
    mode_view          = '0;
    mode_view[SEL_BIT] = sel;
    mode_view[REQ_BIT] = req;
  end

  assign main_reg_rdata = mode_view;
  assign sub_reg_rdata  = mode_view;

  assign unused_wbits = ^{main_reg_wdata[REG_W-1:2], main_reg_wdata[SEL_BIT],
                          sub_reg_wdata[REG_W-1:1]};
endmodule

// File: rtl/wram_swap_chk.sv
module wram_swap_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             main_reg_we,
  input logic [REG_W-1:0] main_reg_wdata,
  input logic [REG_W-1:0] main_reg_rdata,
  input logic             sub_reg_we,
  input logic [REG_W-1:0] sub_reg_wdata,
  input logic [REG_W-1:0] sub_reg_rdata
);
  logic toggle;
  assign toggle = sub_reg_we && (sub_reg_wdata[0] != sub_reg_rdata[0]);

  // R2: without a sub write, bit 0 holds
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_reg_we |=> $stable(main_reg_rdata[0]));

  // R4: sub write without toggle leaves bit 1 alone when main is quiet
  p_sub_req_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_reg_we && !toggle && !main_reg_we) |=> $stable(main_reg_rdata[1]));

  // R5: main write of 0 to bit 1 raises the request
  p_req_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (main_reg_we && !main_reg_wdata[1] && !toggle) |=> main_reg_rdata[1]);

  // R6: pending request persists until a swap
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (main_reg_rdata[1] && !toggle) |=> main_reg_rdata[1]);

  // R7: toggle clears the request and flips bit 0
  p_swap_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |=> (!main_reg_rdata[1] && (main_reg_rdata[0] != $past(main_reg_rdata[0]))));

  // R8: both views agree and upper bits are zero
  always_comb begin
    if (rst_n) begin
      a_views_match_r8: assert (main_reg_rdata == sub_reg_rdata);
      a_upper_zero_r8:  assert (main_reg_rdata[REG_W-1:2] == '0);
    end
  end
endmodule

bind wram_swap_ctrl wram_swap_chk #(.REG_W(REG_W)) u_swap_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .main_reg_we    (main_reg_we),
  .main_reg_wdata (main_reg_wdata),
  .main_reg_rdata (main_reg_rdata),
  .sub_reg_we     (sub_reg_we),
  .sub_reg_wdata  (sub_reg_wdata),
  .sub_reg_rdata  (sub_reg_rdata)
);

// File: tb/test_wram_swap_ctrl.sv
`timescale 1ns/1ps
module test_wram_swap_ctrl;
  localparam int AW = 6;
  localparam int RW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic main_reg_we, sub_reg_we;
  logic [RW-1:0] main_reg_wdata, sub_reg_wdata, main_reg_rdata, sub_reg_rdata;
  logic main_ram_en, sub_ram_en;
  logic [1:0] main_ram_wstrb, sub_ram_wstrb;
  logic [AW-1:0] main_ram_addr, sub_ram_addr;
  logic [15:0] main_ram_wdata, sub_ram_wdata, main_ram_rdata, sub_ram_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wram_swap_ctrl #(.ADDR_W(AW), .REG_W(RW)) i_wram_swap_ctrl (.*);

  // {main_we, main_d[1:0], sub_we, sub_d[1:0], expected[1:0]}
  localparam logic [7:0] VEC [12] = '{
    8'b1_10_0_00_00,  // R5 writing 1 does nothing
    8'b1_01_0_00_10,  // R5 request; R2 bit0 from main ignored
    8'b1_00_0_00_10,  // R6 second request stays 1
    8'b0_00_1_10_10,  // R4 sub bit1 ignored, no toggle
    8'b0_00_1_01_01,  // R7 toggle clears request
    8'b0_00_1_01_01,  // R2 same value, no change
    8'b0_00_1_00_00,  // R7 toggle without request
    8'b1_00_0_00_10,  // R5 request again
    8'b0_00_0_00_10,  // R6 idle holds request
    8'b1_00_1_01_01,  // R7 clear wins over same-cycle request
    8'b0_00_1_11_01,  // R4 sub bit1 ignored
    8'b1_11_0_00_01   // R5 bit1=1 no effect, R2 bit0 ignored
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    main_reg_we = 0; sub_reg_we = 0; main_reg_wdata = '0; sub_reg_wdata = '0;
    main_ram_en = 0; sub_ram_en = 0; main_ram_wstrb = '0; sub_ram_wstrb = '0;
    main_ram_addr = '0; sub_ram_addr = '0; main_ram_wdata = '0; sub_ram_wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 main view in reset", 16'(main_reg_rdata), 16'h0);
    check("R1 sub view in reset", 16'(sub_reg_rdata), 16'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    do_reset();
    check("R1 main view after reset", 16'(main_reg_rdata), 16'h0);
    check("R8 sub view after reset", 16'(sub_reg_rdata), 16'h0);

    for (int i = 0; i < 12; i++) begin
      main_reg_we    = VEC[i][7];
      main_reg_wdata = {6'b0, VEC[i][6:5]};
      sub_reg_we     = VEC[i][4];
      sub_reg_wdata  = {6'b0, VEC[i][3:2]};
      @(negedge clk);
      main_reg_we = 0; sub_reg_we = 0;
      check($sformatf("R5/R6/R7 vector %0d mode", i), 16'(main_reg_rdata), {14'b0, VEC[i][1:0]});
      check($sformatf("R8 vector %0d views", i), 16'(sub_reg_rdata), 16'(main_reg_rdata));
    end

    // Directed RAM tests from a fresh reset (select 0)
    do_reset();
    main_ram_en = 1; main_ram_wstrb = 2'b11; main_ram_addr = 3; main_ram_wdata = 16'h1234;
    sub_ram_en  = 1; sub_ram_wstrb  = 2'b11; sub_ram_addr  = 3; sub_ram_wdata  = 16'hABCD;
    @(negedge clk);
    main_ram_wstrb = 0; sub_ram_wstrb = 0;
    @(negedge clk);
    check("R10 main reads bank A", main_ram_rdata, 16'h1234);
    check("R10 sub reads bank B", sub_ram_rdata, 16'hABCD);

    sub_ram_en = 0;
    main_ram_wstrb = 2'b01; main_ram_wdata = 16'hFF55;
    @(negedge clk);
    main_ram_wstrb = 0;
    sub_reg_we = 1; sub_reg_wdata = 8'h01;
    @(negedge clk);
    sub_reg_we = 0;
    check("R9 low-byte strobe merge, R3 old mapping in toggle cycle", main_ram_rdata, 16'h1255);
    check("R3 select now 1", 16'(main_reg_rdata), 16'h1);
    sub_ram_en = 1;
    @(negedge clk);
    check("R3 main sees bank B after swap", main_ram_rdata, 16'hABCD);
    check("R10 sub sees main's data after swap", sub_ram_rdata, 16'h1255);

    // Top address boundary, select 1: main on B, sub on A
    main_ram_addr = 6'd63; sub_ram_addr = 6'd63;
    main_ram_wstrb = 2'b11; main_ram_wdata = 16'h5A5A;
    sub_ram_wstrb  = 2'b11; sub_ram_wdata  = 16'h7777;
    @(negedge clk);
    sub_ram_en = 0;
    main_ram_wstrb = 2'b10; main_ram_wdata = 16'hC3C3;
    @(negedge clk);
    main_ram_wstrb = 0; sub_ram_en = 1;
    @(negedge clk);
    check("R9 high-byte strobe at top address", main_ram_rdata, 16'hC35A);
    check("R10 sub bank untouched by main writes", sub_ram_rdata, 16'h7777);
    idle();
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule